// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block guards a system against runaway software. A free-running prescaler divides the block clock by a selectable power of two, from 1 to 64. Each divided tick advances an 8-bit watchdog counter. If that counter rolls over from 255, the block asks for a system reset.

Software keeps the watchdog from firing by writing a two-step key. First it writes 0x55, then 0xAA. Only that pair clears the counter. The clear takes effect one cycle late. Any other key value is treated as a sign of faulty software and requests a reset.

A control write sets the divide ratio and a disable bit. It is accepted only if it carries a fixed check pattern. A control write with any other pattern requests a reset at once. Every reset request is stretched into a pulse of at least eight clock cycles.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter reads 0, the reset request is low, the watchdog is enabled and the divide select is 0. In that state the counter advances by one on every clock edge.
- R2: Control bits [2:0] select the divide ratio. A value k makes the counter advance once every 2^k clock cycles. The values 6 and 7 both give one advance every 64 cycles.
- R3: When the counter is at 255 and a tick arrives while the watchdog is enabled, the reset request is raised and the counter wraps to 0.
- R4: A key write of 0x55 followed by a key write of 0xAA clears the counter. The counter is still nonzero after the edge that captures 0xAA, and it reads 0 after the next edge.
- R5: A key write of 0xAA with no armed 0x55 does not clear the counter. A repeated 0x55 keeps the sequence armed. Any key write of another value disarms the sequence.
- R6: A key write of any value other than 0x55 or 0xAA, while the watchdog is enabled, raises the reset request after the capturing edge.
- R7: A control write whose bits [5:3] are not 101 raises the reset request after the capturing edge, whatever the disable bit says. Such a write leaves the stored divide select and disable bit unchanged.
- R8: Control bit 6 set to 1 disables the watchdog. While disabled:
  - the counter holds its value;
  - bad keys and overflow raise no reset;
  - the good-key clear still works.
- R9: Each reset request is held high for exactly 8 cycles, starting from the edge that captures its cause. A new cause during the pulse restarts the 8-cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 7 | Control write data: [2:0] divide select, [5:3] check pattern, [6] disable |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrData | input | 8 | Key value written |
| cntValue | output | 8 | Current watchdog counter value |
| rstReq | output | 1 | Stretched system reset request |

## Verification
The assertions assume the write strobes are single-cycle pulses with their data valid in the same cycle.

The wrap property assumes that a drop from 255 to 0 without a key write two cycles earlier can only come from an overflow. It therefore relies on the key clear being the only other path that zeroes the counter.

The bench drives every write as a one-cycle pulse set up at a falling edge. It spaces key writes so that the counter stays far from 255, except in the one scenario that drives it there on purpose.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int SEL_W   = 3;
  localparam int SEL_LSB = 0;
  localparam int CHK_LSB = 3;
  localparam int DIS_BIT = 6;

  typedef struct packed {
    logic [SEL_W-1:0] divSel;
    logic             countEn;
    logic             clearCnt;
  } wdStrobe_t;
endpackage

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovf
);
  localparam int IDX_W = $clog2(PRE_W + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   tickVec;
  logic [IDX_W-1:0] selIdx;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickVec[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign tickVec[k] = &preCnt[k-1:0];
  end

  always_comb begin
    if (int'(strobe.divSel) > PRE_W) selIdx = IDX_W'(PRE_W);
    else                             selIdx = IDX_W'(strobe.divSel);
  end

  assign tick = tickVec[selIdx];
  assign ovf  = strobe.countEn && tick && !strobe.clearCnt && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN)                        cnt <= '0;
    else if (strobe.clearCnt)         cnt <= '0;
    else if (strobe.countEn && tick)  cnt <= cnt + 1'b1;
  end

  assign cntValue = cnt;
endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl
  import wd_pkg::*;
#(
  parameter int         CTRL_W    = 7,
  parameter int         KEY_W     = 8,
  parameter int         PULSE_LEN = 8,
  parameter logic [7:0] KEY_ARM   = 8'h55,
  parameter logic [7:0] KEY_FIRE  = 8'hAA,
  parameter logic [2:0] CHECK_PAT = 3'b101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              keyWrEn,
  input  logic [KEY_W-1:0]  keyWrData,
  input  logic              ovf,
  output wdStrobe_t         strobe,
  output logic              wdDisabled,
  output logic              rstReq
);
  localparam int ST_W = $clog2(PULSE_LEN + 1);

  logic [SEL_W-1:0] divSel;
  logic             disableBit;
  logic             armed;
  logic             clearDly;
  logic [ST_W-1:0]  stretch;

  logic ctrlChkOk, ctrlBad, keyArm, keyFire, keyGood, keyBad, fire;

  assign ctrlChkOk = ctrlWrData[CHK_LSB +: 3] == CHECK_PAT;
  assign ctrlBad   = ctrlWrEn && !ctrlChkOk;
  assign keyArm    = keyWrEn && (keyWrData == KEY_W'(KEY_ARM));
  assign keyFire   = keyWrEn && (keyWrData == KEY_W'(KEY_FIRE));
  assign keyGood   = keyFire && armed;
  assign keyBad    = keyWrEn && !keyArm && !keyFire;
  assign fire      = ctrlBad || (!disableBit && (keyBad || ovf));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSel     <= '0;
      disableBit <= 1'b0;
    end else if (ctrlWrEn && ctrlChkOk) begin
      divSel     <= ctrlWrData[SEL_LSB +: SEL_W];
      disableBit <= ctrlWrData[DIS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      clearDly <= 1'b0;
    end else begin
      if (keyWrEn) armed <= keyArm;
      clearDly <= keyGood;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             stretch <= '0;
    else if (fire)         stretch <= ST_W'(PULSE_LEN);
    else if (stretch != 0) stretch <= stretch - 1'b1;
  end

  assign rstReq          = stretch != '0;
  assign wdDisabled      = disableBit;
  assign strobe.divSel   = divSel;
  assign strobe.countEn  = !disableBit;
  assign strobe.clearCnt = clearDly;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wd_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 6,
  parameter int CTRL_W    = 7,
  parameter int KEY_W     = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              keyWrEn,
  input  logic [KEY_W-1:0]  keyWrData,
  output logic [CNT_W-1:0]  cntValue,
  output logic              rstReq
);
  wdStrobe_t strobe;
  logic      ovf;
  logic      wdDisabled;

  wd_ctrl #(
    .CTRL_W(CTRL_W), .KEY_W(KEY_W), .PULSE_LEN(PULSE_LEN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .ovf(ovf), .strobe(strobe), .wdDisabled(wdDisabled), .rstReq(rstReq)
  );

  wd_datapath #(
    .CNT_W(CNT_W), .PRE_W(PRE_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntValue(cntValue), .ovf(ovf)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W     = 8,
  parameter int CTRL_W    = 7,
  parameter int KEY_W     = 8,
  parameter int PULSE_LEN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic              keyWrEn,
  input logic [KEY_W-1:0]  keyWrData,
  input logic [CNT_W-1:0]  cntValue,
  input logic              rstReq,
  input logic              wdDisabled
);
  logic [4:0] hiLen;

  always_ff @(posedge clk) begin
    if (!rstN)       hiLen <= '0;
    else if (rstReq) hiLen <= (hiLen == 5'h1F) ? hiLen : hiLen + 5'd1;
    else             hiLen <= '0;
  end

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> hiLen >= 5'(PULSE_LEN)); // R9

  AST_CHECK_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[5:3] != 3'b101) |=> rstReq); // R7

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && keyWrData != KEY_W'(8'h55) && keyWrData != KEY_W'(8'hAA) && !wdDisabled)
      |=> rstReq); // R6

  AST_WRAP_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (cntValue == '1 && !$past(keyWrEn)) ##1 (cntValue == '0) |-> rstReq); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntValue != $past(cntValue)) |->
      (cntValue == $past(cntValue) + 1'b1 || cntValue == '0)); // R2

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wdDisabled) && !$past(keyWrEn, 2)) |-> cntValue == $past(cntValue)); // R8
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .CNT_W(CNT_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W), .PULSE_LEN(PULSE_LEN)
) i_chk (.*);

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [6:0] ctrlWrData = '0;
  logic       keyWrEn = 1'b0;
  logic [7:0] keyWrData = '0;
  logic [7:0] cntValue;
  logic       rstReq;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .keyWrEn(keyWrEn), .keyWrData(keyWrData), .cntValue(cntValue), .rstReq(rstReq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCtrl(logic dis, logic [2:0] chk, logic [2:0] sel);
    ctrlWrData = {dis, chk, sel};
    ctrlWrEn   = 1'b1;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
  endtask

  task automatic writeKey(logic [7:0] v);
    keyWrData = v;
    keyWrEn   = 1'b1;
    @(negedge clk);
    keyWrEn   = 1'b0;
  endtask

  function automatic int pulseLen();
    return 0;
  endfunction

  task automatic measurePulse(output int n);
    n = 0;
    while (rstReq && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check("R1 counter after reset", cntValue, 0);
    check("R1 request after reset", rstReq, 0);
    waitCyc(4);
    check("R1 enabled divide-by-1", cntValue, 4);
  endtask

  task automatic testDisable();
    int c;
    writeCtrl(1'b1, 3'b101, 3'd0);
    c = cntValue;
    waitCyc(40);
    check("R8 counter holds while disabled", cntValue, c);
    writeKey(8'h12);
    check("R8 bad key ignored while disabled", rstReq, 0);
    waitCyc(3);
    check("R8 no late request", rstReq, 0);
  endtask

  task automatic testCheckGuard();
    int n, c;
    writeCtrl(1'b0, 3'b011, 3'd0);
    check("R7 bad check field requests reset", rstReq, 1);
    measurePulse(n);
    check("R9 pulse length", n, 8);
    c = cntValue;
    waitCyc(20);
    check("R7 config unchanged, still disabled", cntValue, c);
  endtask

  task automatic testDivide(logic [2:0] sel, int period);
    int c;
    writeCtrl(1'b0, 3'b101, sel);
    waitCyc(2);
    c = cntValue;
    waitCyc(4 * period);
    check($sformatf("R2 advance with select %0d", sel), cntValue - c, 4);
  endtask

  task automatic testKeys();
    int c, n;
    writeCtrl(1'b0, 3'b101, 3'd0);
    writeKey(8'h55);
    writeKey(8'hAA);
    check("R4 not yet cleared at capture edge", cntValue != 0, 1);
    waitCyc(1);
    check("R4 cleared one cycle later", cntValue, 0);
    waitCyc(5);
    c = cntValue;
    writeKey(8'hAA);
    waitCyc(1);
    check("R5 lone 0xAA does not clear", cntValue, c + 2);
    writeKey(8'h55);
    writeKey(8'h55);
    writeKey(8'hAA);
    waitCyc(1);
    check("R5 repeated 0x55 stays armed", cntValue, 0);
    waitCyc(3);
    writeKey(8'h55);
    writeKey(8'h3C);
    check("R6 bad key requests reset", rstReq, 1);
    c = cntValue;
    writeKey(8'hAA);
    waitCyc(1);
    check("R5 bad key disarms sequence", cntValue, c + 2);
    measurePulse(n);
    waitCyc(2);
  endtask

  task automatic testOverflow();
    int n, len;
    writeKey(8'h55);
    writeKey(8'hAA);
    n = 0;
    while (!rstReq && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R3 cycles from clear to overflow request", n, 257);
    check("R3 counter wrapped", cntValue, 0);
    measurePulse(len);
    check("R9 overflow pulse length", len, 8);
  endtask

  task automatic testRetrigger();
    int n;
    writeKey(8'h01);
    waitCyc(4);
    writeKey(8'h02);
    measurePulse(n);
    check("R9 retrigger restarts count", n, 8);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    testReset();
    testDisable();
    testCheckGuard();
    testDivide(3'd2, 4);
    testDivide(3'd4, 16);
    testDivide(3'd6, 64);
    testDivide(3'd7, 64);
    testKeys();
    testOverflow();
    testRetrigger();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule